// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block sits between the command register of a multi-channel half-bridge driver and its gate drivers. Each bridge has a low-side and a high-side switch. A host writes a command word through a load strobe: six switch requests, an overcurrent-shutdown enable and a status-reset bit. The block decides which gates may really be driven. It watches digitized comparator flags from the power stage: per-switch overcurrent, per-switch open load, per-switch thermal warning and thermal shutdown, and one supply undervoltage flag. From these it keeps the diagnostic flags that a serial status frame later reads.

Each fault class has its own rule. An undervoltage must persist through a tick-count filter before it counts. It then blocks every gate and latches the supply-fail flag, and the gates come back by themselves once the supply recovers. Overcurrent is filtered as well and always latches the short-circuit flag. It turns the affected switch off only when shutdown is enabled. Open load on a conducting switch latches its own flag after a longer filter. Thermal shutdown blocks every gate until the die has cooled and a status reset is written. The warning flag follows its comparator and is not latched. Driving the inhibit input low holds the whole block in reset. Releasing it acts as a fresh power-on.

No bridge ever drives both of its gates. A switch turns on only after a programmable dead-time count has elapsed since its partner turned off.

Top module: `hb_fault_supervisor`

## Requirements
- R1: After reset all gate enables and all four diagnostic flags are low.
- R2: A command takes effect only when `cmd_load` is high. The gate enables reflect the loaded requests two clock edges after the load edge, and changes on the command inputs without a load have no effect.
- R3: The low-side and high-side gates of one bridge are never high together. If both are requested, both stay low while the other bridges are unaffected.
- R4: After a gate of a bridge falls, its partner stays low for at least `dead_cnt`+1 clock cycles. With no other blocking condition, the partner rises exactly `dead_cnt`+2 edges after the load that swaps them.
- R5: An undervoltage that stays high for UV_FILT consecutive clock edges forces all gates low and sets `flag_supply`.
- R6: When the undervoltage input falls, the gates return to the loaded requests within two edges, while `flag_supply` stays set.
- R7: With overcurrent shutdown enabled (`cmd_ocs_en`=1), an overcurrent on a conducting switch held for SC_FILT edges turns that switch off and sets `flag_short`. Other switches keep running, and the switch stays off after the overcurrent ends.
- R8: With overcurrent shutdown disabled, the same overcurrent sets `flag_short` but leaves every gate enable unchanged.
- R9: A load with `cmd_status_rst`=1 clears `flag_supply`, `flag_short` and `flag_open` and re-enables switches turned off by overcurrent. The gates then follow the requests loaded with it.
- R10: An open-load indication on a conducting switch held for OL_FILT edges sets `flag_open`, which stays set until a status reset. Indications on switches that are off are ignored.
- R11: `flag_warn` equals the OR of the thermal-warning inputs one edge later and is not latched.
- R12: Any thermal-shutdown input forces all gates low from the next edge. The gates return only after every shutdown input is low and a status reset is loaded, and a status reset loaded while a shutdown input is high has no effect.
- R13: While `inhibit_n` is low, all gates and flags are low. After it rises, the gates stay low until a new command is loaded.
- R14: A filtered condition that drops out before its filter count completes restarts the count, so repeated short pulses never set a flag or remove a gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; filter and dead-time counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_n | input | 1 | Low holds the block in reset (standby) |
| cmd_load | input | 1 | Loads the command fields on this edge |
| cmd_req_lo | input | NUM_BRIDGES | Low-side switch requests, bit b = bridge b |
| cmd_req_hi | input | NUM_BRIDGES | High-side switch requests, bit b = bridge b |
| cmd_ocs_en | input | 1 | 1 = overcurrent turns the switch off |
| cmd_status_rst | input | 1 | 1 with a load = clear latched flags and trips |
| dead_cnt | input | DEAD_W | Dead-time count between partner gates |
| uv_in | input | 1 | Supply undervoltage comparator |
| oc_lo_in | input | NUM_BRIDGES | Overcurrent comparators, low sides |
| oc_hi_in | input | NUM_BRIDGES | Overcurrent comparators, high sides |
| ol_lo_in | input | NUM_BRIDGES | Open-load comparators, low sides |
| ol_hi_in | input | NUM_BRIDGES | Open-load comparators, high sides |
| therm_warn_in | input | 2*NUM_BRIDGES | Thermal-warning comparators, any switch |
| therm_shut_in | input | 2*NUM_BRIDGES | Thermal-shutdown comparators, any switch |
| gate_lo | output | NUM_BRIDGES | Effective low-side gate enables |
| gate_hi | output | NUM_BRIDGES | Effective high-side gate enables |
| flag_warn | output | 1 | Thermal warning, follows comparators |
| flag_short | output | 1 | Latched short-circuit flag |
| flag_open | output | 1 | Latched open-load flag |
| flag_supply | output | 1 | Latched supply-fail flag |

## Verification
The command register takes one edge and the gate register a second, so gate enables are sampled at least two edges after a load. A filter reports on the edge that sees its count reach the limit, and the resulting flag or gate change appears one edge later. The scenarios therefore hold a fault for the filter count plus a margin of two or three cycles before sampling. The restart cases use pulses one or more edges short of the count. The dead-time scenario counts every sampled cycle in which both gates of the bridge are low and compares that count with `dead_cnt`+1 for two dead-time settings. All samples are taken on the falling clock edge, after the rising edge that updates the registers.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

   // side index inside one bridge leg
   typedef enum logic {
      SIDE_LO = 1'b0,
      SIDE_HI = 1'b1
   } hb_side_e;

   // latched diagnostics; the warning flag is kept apart because it is not latched
   typedef struct packed {
      logic supply;
      logic short_ckt;
      logic open_ld;
   } hb_latch_t;

endpackage

// File: rtl/hb_tick_filter.sv
module hb_tick_filter #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TERM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   // count consecutive edges with cond high; any drop-out restarts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!cond)        cnt_q <= '0;
      else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
   end

   assign hit = cond && (cnt_q == TERM);

endmodule

// File: rtl/hb_switch_guard.sv
module hb_switch_guard #(
   parameter int SC_FILT = 16,
   parameter int OL_FILT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_on,
   input  logic oc_in,
   input  logic ol_in,
   input  logic ocs_en,
   input  logic srr,
   output logic sc_hit,
   output logic ol_hit,
   output logic tripped
);
   logic oc_cond, ol_cond;

   // faults only count while the switch conducts
   assign oc_cond = gate_on & oc_in;
   assign ol_cond = gate_on & ol_in;

   hb_tick_filter #(.LIMIT(SC_FILT)) u_sc_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (oc_cond),
      .hit  (sc_hit)
   );

   hb_tick_filter #(.LIMIT(OL_FILT)) u_ol_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (ol_cond),
      .hit  (ol_hit)
   );

   // shutdown latch: set wins over a simultaneous status reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tripped <= 1'b0;
      else if (sc_hit && ocs_en) tripped <= 1'b1;
      else if (srr)              tripped <= 1'b0;
   end

endmodule

// File: rtl/hb_bridge_leg.sv
module hb_bridge_leg
   import hb_sup_pkg::*;
#(
   parameter int DEAD_W  = 6,
   parameter int SC_FILT = 16,
   parameter int OL_FILT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_lo,
   input  logic              req_hi,
   input  logic              block_all,
   input  logic              ocs_en,
   input  logic              srr,
   input  logic [DEAD_W-1:0] dead_cnt,
   input  logic              oc_lo,
   input  logic              oc_hi,
   input  logic              ol_lo,
   input  logic              ol_hi,
   output logic              gate_lo,
   output logic              gate_hi,
   output logic              sc_hit,
   output logic              ol_hit
);
   localparam int LO = int'(SIDE_LO);
   localparam int HI = int'(SIDE_HI);

   logic [1:0] req, oc, ol, gate, trip, sch, olh;
   logic       conflict;

   assign req      = {req_hi, req_lo};
   assign oc       = {oc_hi, oc_lo};
   assign ol       = {ol_hi, ol_lo};
   assign conflict = req_lo & req_hi;

   for (genvar s = 0; s < 2; s++) begin : g_side
      logic [DEAD_W-1:0] dt_q;
      logic              gate_q;
      logic              allow;

      hb_switch_guard #(
         .SC_FILT(SC_FILT),
         .OL_FILT(OL_FILT)
      ) u_guard (
         .clk    (clk),
         .rst_n  (rst_n),
         .gate_on(gate_q),
         .oc_in  (oc[s]),
         .ol_in  (ol[s]),
         .ocs_en (ocs_en),
         .srr    (srr),
         .sc_hit (sch[s]),
         .ol_hit (olh[s]),
         .tripped(trip[s])
      );

      assign allow = req[s] & ~conflict & ~trip[s] & ~block_all;

      // dead-time counter reloads while the partner conducts, drains after
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dt_q   <= '0;
            gate_q <= 1'b0;
         end else begin
            if (gate[1-s])       dt_q <= dead_cnt;
            else if (dt_q != '0) dt_q <= dt_q - 1'b1;
            gate_q <= allow & ~gate[1-s] & (dt_q == '0);
         end
      end

      assign gate[s] = gate_q;
   end

   assign gate_lo = gate[LO];
   assign gate_hi = gate[HI];
   assign sc_hit  = |sch;
   assign ol_hit  = |olh;

endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
   import hb_sup_pkg::*;
#(
   parameter int NUM_BRIDGES = 3,
   parameter int DEAD_W      = 6,
   parameter int UV_FILT     = 4000,
   parameter int SC_FILT     = 4000,
   parameter int OL_FILT     = 80000,
   parameter bit REG_WARN    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inhibit_n,
   input  logic                     cmd_load,
   input  logic [NUM_BRIDGES-1:0]   cmd_req_lo,
   input  logic [NUM_BRIDGES-1:0]   cmd_req_hi,
   input  logic                     cmd_ocs_en,
   input  logic                     cmd_status_rst,
   input  logic [DEAD_W-1:0]        dead_cnt,
   input  logic                     uv_in,
   input  logic [NUM_BRIDGES-1:0]   oc_lo_in,
   input  logic [NUM_BRIDGES-1:0]   oc_hi_in,
   input  logic [NUM_BRIDGES-1:0]   ol_lo_in,
   input  logic [NUM_BRIDGES-1:0]   ol_hi_in,
   input  logic [2*NUM_BRIDGES-1:0] therm_warn_in,
   input  logic [2*NUM_BRIDGES-1:0] therm_shut_in,
   output logic [NUM_BRIDGES-1:0]   gate_lo,
   output logic [NUM_BRIDGES-1:0]   gate_hi,
   output logic                     flag_warn,
   output logic                     flag_short,
   output logic                     flag_open,
   output logic                     flag_supply
);
   localparam int SW = 2 * NUM_BRIDGES;

   initial begin : prm_chk
      assert (NUM_BRIDGES >= 1) else $error("NUM_BRIDGES must be at least 1");
      assert (DEAD_W >= 1)      else $error("DEAD_W must be at least 1");
      assert (UV_FILT >= 2)     else $error("UV_FILT must be at least 2");
      assert (SC_FILT >= 2)     else $error("SC_FILT must be at least 2");
      assert (OL_FILT >= 2)     else $error("OL_FILT must be at least 2");
      assert (SW == 2 * NUM_BRIDGES) else $error("switch count mismatch");
   end

   // standby is a full reset of the block
   logic rst_int_n;
   assign rst_int_n = rst_n & inhibit_n;

   // command register
   logic [NUM_BRIDGES-1:0] req_lo_q, req_hi_q;
   logic                   ocs_q;
   logic                   srr;

   always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
         req_lo_q <= '0;
         req_hi_q <= '0;
         ocs_q    <= 1'b1;
      end else if (cmd_load) begin
         req_lo_q <= cmd_req_lo;
         req_hi_q <= cmd_req_hi;
         ocs_q    <= cmd_ocs_en;
      end
   end

   assign srr = cmd_load & cmd_status_rst;

   // supply undervoltage, filtered; releases as soon as the input drops
   logic uv_hit;

   hb_tick_filter #(.LIMIT(UV_FILT)) u_uv_filt (
      .clk  (clk),
      .rst_n(rst_int_n),
      .cond (uv_in),
      .hit  (uv_hit)
   );

   // thermal shutdown latch: cleared only by a reset written when cool
   logic tsd_any, tsd_q;
   assign tsd_any = |therm_shut_in;

   always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)    tsd_q <= 1'b0;
      else if (tsd_any)  tsd_q <= 1'b1;
      else if (srr)      tsd_q <= 1'b0;
   end

   logic block_all;
   assign block_all = uv_hit | tsd_q | tsd_any;

   // bridge legs
   logic [NUM_BRIDGES-1:0] leg_sc, leg_ol;

   for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_leg
      hb_bridge_leg #(
         .DEAD_W (DEAD_W),
         .SC_FILT(SC_FILT),
         .OL_FILT(OL_FILT)
      ) u_leg (
         .clk      (clk),
         .rst_n    (rst_int_n),
         .req_lo   (req_lo_q[b]),
         .req_hi   (req_hi_q[b]),
         .block_all(block_all),
         .ocs_en   (ocs_q),
         .srr      (srr),
         .dead_cnt (dead_cnt),
         .oc_lo    (oc_lo_in[b]),
         .oc_hi    (oc_hi_in[b]),
         .ol_lo    (ol_lo_in[b]),
         .ol_hi    (ol_hi_in[b]),
         .gate_lo  (gate_lo[b]),
         .gate_hi  (gate_hi[b]),
         .sc_hit   (leg_sc[b]),
         .ol_hit   (leg_ol[b])
      );
   end

   // latched diagnostics: a live fault wins over a status reset
   hb_latch_t diag_q;

   always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
         diag_q <= '0;
      end else begin
         if (uv_hit)       diag_q.supply <= 1'b1;
         else if (srr)     diag_q.supply <= 1'b0;
         if (|leg_sc)      diag_q.short_ckt <= 1'b1;
         else if (srr)     diag_q.short_ckt <= 1'b0;
         if (|leg_ol)      diag_q.open_ld <= 1'b1;
         else if (srr)     diag_q.open_ld <= 1'b0;
      end
   end

   assign flag_supply = diag_q.supply;
   assign flag_short  = diag_q.short_ckt;
   assign flag_open   = diag_q.open_ld;

   // warning flag: registered or transparent variant
   if (REG_WARN) begin : g_warn_reg
      logic warn_q;
      always_ff @(posedge clk or negedge rst_int_n) begin
         if (!rst_int_n) warn_q <= 1'b0;
         else            warn_q <= |therm_warn_in;
      end
      assign flag_warn = warn_q;
   end else begin : g_warn_comb
      assign flag_warn = rst_int_n & (|therm_warn_in);
   end

endmodule

// File: rtl/hb_sup_chk.sv
module hb_sup_chk #(
   parameter int NUM_BRIDGES = 3,
   parameter int DEAD_W      = 6,
   parameter bit REG_WARN    = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     inhibit_n,
   input logic                     cmd_load,
   input logic                     cmd_status_rst,
   input logic [DEAD_W-1:0]        dead_cnt,
   input logic                     uv_in,
   input logic [2*NUM_BRIDGES-1:0] therm_warn_in,
   input logic [2*NUM_BRIDGES-1:0] therm_shut_in,
   input logic [NUM_BRIDGES-1:0]   gate_lo,
   input logic [NUM_BRIDGES-1:0]   gate_hi,
   input logic                     flag_warn,
   input logic                     flag_short,
   input logic                     flag_open,
   input logic                     flag_supply
);
   logic live;
   assign live = rst_n & inhibit_n;

   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!live)
      (gate_lo & gate_hi) == '0);

   // per-bridge off-time counters for the dead-time window
   localparam logic [DEAD_W:0] OFF_MAX = '1;

   for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_dead
      logic [DEAD_W:0] lo_off_q, hi_off_q;

      always_ff @(posedge clk or negedge live) begin
         if (!live) begin
            lo_off_q <= OFF_MAX;
            hi_off_q <= OFF_MAX;
         end else begin
            lo_off_q <= gate_lo[b] ? '0 : ((lo_off_q == OFF_MAX) ? OFF_MAX : lo_off_q + 1'b1);
            hi_off_q <= gate_hi[b] ? '0 : ((hi_off_q == OFF_MAX) ? OFF_MAX : hi_off_q + 1'b1);
         end
      end

      // R4
      dead_gap_hi_chk: assert property (@(posedge clk) disable iff (!live)
         $rose(gate_hi[b]) |-> (lo_off_q > {1'b0, dead_cnt}));

      // R4
      dead_gap_lo_chk: assert property (@(posedge clk) disable iff (!live)
         $rose(gate_lo[b]) |-> (hi_off_q > {1'b0, dead_cnt}));
   end

   // R5
   supply_set_chk: assert property (@(posedge clk) disable iff (!live)
      $rose(flag_supply) |-> $past(uv_in));

   // R9
   supply_clr_chk: assert property (@(posedge clk) disable iff (!live)
      $fell(flag_supply) |-> $past(cmd_load && cmd_status_rst));

   // R9
   short_clr_chk: assert property (@(posedge clk) disable iff (!live)
      $fell(flag_short) |-> $past(cmd_load && cmd_status_rst));

   // R10
   open_clr_chk: assert property (@(posedge clk) disable iff (!live)
      $fell(flag_open) |-> $past(cmd_load && cmd_status_rst));

   // R12
   shut_off_chk: assert property (@(posedge clk) disable iff (!live)
      (|therm_shut_in) |=> (gate_lo == '0 && gate_hi == '0));

   if (REG_WARN) begin : g_warn_chk
      // R11
      warn_follow_chk: assert property (@(posedge clk) disable iff (!live)
         (|therm_warn_in) |=> flag_warn);
      // R11
      warn_release_chk: assert property (@(posedge clk) disable iff (!live)
         !(|therm_warn_in) |=> !flag_warn);
   end else begin : g_warn_chk
      // R11
      warn_follow_chk: assert property (@(posedge clk) disable iff (!live)
         flag_warn == (|therm_warn_in));
   end

endmodule

bind hb_fault_supervisor hb_sup_chk #(
   .NUM_BRIDGES(NUM_BRIDGES),
   .DEAD_W     (DEAD_W),
   .REG_WARN   (REG_WARN)
) u_sup_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .inhibit_n     (inhibit_n),
   .cmd_load      (cmd_load),
   .cmd_status_rst(cmd_status_rst),
   .dead_cnt      (dead_cnt),
   .uv_in         (uv_in),
   .therm_warn_in (therm_warn_in),
   .therm_shut_in (therm_shut_in),
   .gate_lo       (gate_lo),
   .gate_hi       (gate_hi),
   .flag_warn     (flag_warn),
   .flag_short    (flag_short),
   .flag_open     (flag_open),
   .flag_supply   (flag_supply)
);

// File: tb/hb_fault_supervisor_test.sv
`timescale 1ns/1ps
module hb_fault_supervisor_test;
   localparam int NB   = 3;
   localparam int DW   = 4;
   localparam int UVF  = 6;
   localparam int SCF  = 5;
   localparam int OLF  = 12;

   logic          clk = 1'b0;
   logic          rst_n, inhibit_n, cmd_load, cmd_ocs_en, cmd_status_rst, uv_in;
   logic [NB-1:0] cmd_req_lo, cmd_req_hi, oc_lo_in, oc_hi_in, ol_lo_in, ol_hi_in;
   logic [DW-1:0] dead_cnt;
   logic [2*NB-1:0] therm_warn_in, therm_shut_in;
   logic [NB-1:0] gate_lo, gate_hi;
   logic          flag_warn, flag_short, flag_open, flag_supply;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hb_fault_supervisor #(
      .NUM_BRIDGES(NB), .DEAD_W(DW), .UV_FILT(UVF), .SC_FILT(SCF), .OL_FILT(OLF), .REG_WARN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .cmd_load(cmd_load),
      .cmd_req_lo(cmd_req_lo), .cmd_req_hi(cmd_req_hi), .cmd_ocs_en(cmd_ocs_en),
      .cmd_status_rst(cmd_status_rst), .dead_cnt(dead_cnt), .uv_in(uv_in),
      .oc_lo_in(oc_lo_in), .oc_hi_in(oc_hi_in), .ol_lo_in(ol_lo_in), .ol_hi_in(ol_hi_in),
      .therm_warn_in(therm_warn_in), .therm_shut_in(therm_shut_in),
      .gate_lo(gate_lo), .gate_hi(gate_hi), .flag_warn(flag_warn), .flag_short(flag_short),
      .flag_open(flag_open), .flag_supply(flag_supply)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic load_cmd(input logic [NB-1:0] lo, input logic [NB-1:0] hi,
                           input logic ocs, input logic srr);
      cmd_req_lo = lo; cmd_req_hi = hi; cmd_ocs_en = ocs; cmd_status_rst = srr;
      cmd_load = 1'b1;
      @(negedge clk);
      cmd_load = 1'b0; cmd_status_rst = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 gate_lo after reset", gate_lo, 0);
      check("R1 gate_hi after reset", gate_hi, 0);
      check("R1 flags after reset", {flag_warn, flag_short, flag_open, flag_supply}, 0);
   endtask

   task automatic t_load;
      load_cmd(3'b001, 3'b100, 1'b1, 1'b0);
      tick(1);
      check("R2 gate_lo follows load", gate_lo, 3'b001);
      check("R2 gate_hi follows load", gate_hi, 3'b100);
      cmd_req_lo = 3'b111; cmd_req_hi = 3'b000;
      tick(3);
      check("R2 no load, gates unchanged", {gate_hi, gate_lo}, {3'b100, 3'b001});
   endtask

   task automatic t_both;
      load_cmd(3'b011, 3'b010, 1'b1, 1'b0);
      tick(3);
      check("R3 conflicting bridge off", {gate_hi[1], gate_lo[1]}, 0);
      check("R3 other bridges kept", {gate_hi, gate_lo}, {3'b000, 3'b001});
   endtask

   task automatic t_dead(input logic [DW-1:0] d);
      int gap = 0;
      dead_cnt = d;
      load_cmd(3'b001, 3'b000, 1'b1, 1'b0);
      tick(d + 4);
      load_cmd(3'b000, 3'b001, 1'b1, 1'b0);
      for (int i = 0; i < 40; i++) begin
         if (gate_hi[0]) break;
         if (!gate_lo[0]) gap++;
         @(negedge clk);
      end
      check("R4 dead gap cycles", gap, d + 1);
      check("R4 partner reached on", gate_hi[0], 1'b1);
   endtask

   task automatic t_uv;
      load_cmd(3'b001, 3'b100, 1'b1, 1'b0);
      tick(4);
      for (int k = 0; k < 2; k++) begin
         uv_in = 1'b1; tick(UVF - 1);
         uv_in = 1'b0; tick(1);
      end
      tick(1);
      check("R14 short undervoltage ignored", {flag_supply, gate_hi, gate_lo}, {1'b0, 3'b100, 3'b001});
      uv_in = 1'b1; tick(UVF + 2);
      check("R5 undervoltage gates off", {gate_hi, gate_lo}, 0);
      check("R5 supply flag set", flag_supply, 1'b1);
      uv_in = 1'b0; tick(2);
      check("R6 gates return", {gate_hi, gate_lo}, {3'b100, 3'b001});
      check("R6 supply flag held", flag_supply, 1'b1);
      load_cmd(3'b001, 3'b100, 1'b1, 1'b1);
      tick(1);
      check("R9 supply flag cleared", flag_supply, 1'b0);
      check("R9 gates keep requests", {gate_hi, gate_lo}, {3'b100, 3'b001});
   endtask

   task automatic t_oc_shut;
      oc_lo_in = 3'b001; tick(SCF + 3);
      check("R7 shorted switch off", gate_lo, 3'b000);
      check("R7 other switch kept", gate_hi, 3'b100);
      check("R7 short flag", flag_short, 1'b1);
      oc_lo_in = 3'b000; tick(3);
      check("R7 switch stays off", gate_lo, 3'b000);
      load_cmd(3'b001, 3'b100, 1'b1, 1'b1);
      tick(2);
      check("R9 short cleared", flag_short, 1'b0);
      check("R9 switch re-enabled", gate_lo, 3'b001);
   endtask

   task automatic t_oc_flag;
      load_cmd(3'b001, 3'b100, 1'b0, 1'b0);
      tick(2);
      oc_hi_in = 3'b100; tick(SCF + 3);
      check("R8 short flag without shutdown", flag_short, 1'b1);
      check("R8 gates untouched", {gate_hi, gate_lo}, {3'b100, 3'b001});
      oc_hi_in = 3'b000;
      load_cmd(3'b001, 3'b100, 1'b1, 1'b1);
      tick(1);
      check("R9 short cleared again", flag_short, 1'b0);
   endtask

   task automatic t_ol;
      ol_lo_in = 3'b010; tick(OLF + 3);
      check("R10 open load on off switch ignored", flag_open, 1'b0);
      ol_lo_in = 3'b001; tick(OLF - 2);
      ol_lo_in = 3'b000; tick(1);
      ol_lo_in = 3'b001; tick(OLF - 2);
      ol_lo_in = 3'b000; tick(2);
      check("R14 open-load filter restarts", flag_open, 1'b0);
      ol_lo_in = 3'b001; tick(OLF + 3);
      check("R10 open load flagged", flag_open, 1'b1);
      check("R10 gates untouched", {gate_hi, gate_lo}, {3'b100, 3'b001});
      ol_lo_in = 3'b000; tick(3);
      check("R10 open flag sticky", flag_open, 1'b1);
      load_cmd(3'b001, 3'b100, 1'b1, 1'b1);
      tick(1);
      check("R9 open flag cleared", flag_open, 1'b0);
   endtask

   task automatic t_warn;
      therm_warn_in = 6'b001000; tick(2);
      check("R11 warning follows", flag_warn, 1'b1);
      check("R11 gates unaffected", {gate_hi, gate_lo}, {3'b100, 3'b001});
      therm_warn_in = '0; tick(2);
      check("R11 warning not latched", flag_warn, 1'b0);
   endtask

   task automatic t_tsd;
      therm_shut_in = 6'b000001; tick(3);
      check("R12 shutdown gates off", {gate_hi, gate_lo}, 0);
      therm_shut_in = '0; tick(3);
      check("R12 stays off after cooling", {gate_hi, gate_lo}, 0);
      therm_shut_in = 6'b000001;
      load_cmd(3'b001, 3'b100, 1'b1, 1'b1);
      therm_shut_in = '0; tick(3);
      check("R12 reset while hot ignored", {gate_hi, gate_lo}, 0);
      load_cmd(3'b001, 3'b100, 1'b1, 1'b1);
      tick(2);
      check("R12 gates back after cool reset", {gate_hi, gate_lo}, {3'b100, 3'b001});
   endtask

   task automatic t_inh;
      uv_in = 1'b1; tick(UVF + 2);
      uv_in = 1'b0; tick(2);
      check("R13 precondition supply flag", flag_supply, 1'b1);
      inhibit_n = 1'b0; tick(2);
      check("R13 inhibit gates off", {gate_hi, gate_lo}, 0);
      check("R13 inhibit flags cleared", {flag_warn, flag_short, flag_open, flag_supply}, 0);
      inhibit_n = 1'b1; tick(3);
      check("R13 requests cleared by inhibit", {gate_hi, gate_lo}, 0);
      load_cmd(3'b010, 3'b000, 1'b1, 1'b0);
      tick(2);
      check("R13 new load after inhibit", gate_lo, 3'b010);
   endtask

   initial begin
      rst_n = 1'b0; inhibit_n = 1'b1; cmd_load = 1'b0; cmd_ocs_en = 1'b1; cmd_status_rst = 1'b0;
      cmd_req_lo = '0; cmd_req_hi = '0; dead_cnt = '0; uv_in = 1'b0;
      oc_lo_in = '0; oc_hi_in = '0; ol_lo_in = '0; ol_hi_in = '0;
      therm_warn_in = '0; therm_shut_in = '0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset;
      t_load;
      t_both;
      t_dead(4'd3);
      t_dead(4'd0);
      t_uv;
      t_oc_shut;
      t_oc_flag;
      t_ol;
      t_warn;
      t_tsd;
      t_inh;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule